// File: doc/BRIEF.md
# MSI-X Interrupt Write Generator

This block sits on the application side of a PCI Express endpoint and turns interrupt requests into MSI-X memory write packets. A request names a vector. The block keeps a small table of vectors in local registers, and each entry holds a 64-bit target address, a 32-bit message value and a control word. When a vector may be signalled, the block builds a memory write request that carries exactly one dword of payload. It presents the packet one 32-bit beat at a time on a valid/ready transmit port, with start and end markers.

Requests are never dropped. Each request sets a pending bit for its vector, and that bit stays set until the packet for the vector is launched. A vector can be launched only under three conditions: the configuration enable is set, the configuration function mask is clear, and the vector's own mask bit is clear. When several vectors wait, the lowest-numbered eligible vector goes first. The host programs the table through a simple word-write port, addressed by entry index and field select.

Top module: `msix_tlp_gen`

## Requirements
- R1: Each packet is a memory write with a length field of 1. The first header dword is 32'h4000_0001 (three-dword header) when the upper 32 address bits of the entry are zero, and 32'h6000_0001 (four-dword header) otherwise.
- R2: The second header dword is {requester id[15:0], tag 8'h00, last byte enable 4'b0000, first byte enable 4'b1111}.
- R3: In a three-dword header, the third dword is {address[31:2], 2'b00} and the payload follows it. In a four-dword header, address[63:32] comes first, then {address[31:2], 2'b00}, then the payload. The payload is the entry's 32-bit message value.
- R4: No packet starts while cfg_msix_en is 0. A request made in that state stays pending and is sent after the enable is set.
- R5: No packet starts while cfg_func_mask is 1. A request made in that state stays pending and is sent after the mask clears.
- R6: Bit 0 of an entry's control word masks that vector. A request for a masked vector stays pending and is sent once the bit is written to 0.
- R7: pend_o[v] is set from the cycle after a request for vector v. It clears in the cycle after that vector's packet is launched.
- R8: When several pending vectors are eligible, the lowest-numbered one is sent first.
- R9: A beat holds its data and markers while tx_ready is low. Once a packet starts, its beats follow with no idle cycle. tx_sop marks the first beat and tx_eop marks the last beat.
- R10: After reset, tx_valid and pend_o are 0 and every vector's mask bit is 1.
- R11: The table write port selects a field by tbl_sel: 0 is address low, 1 is address high, 2 is message value, 3 is control. The table entry is captured when a packet is launched, so a write during its transmission does not change that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_msix_en | input | 1 | MSI-X enable from configuration space |
| cfg_func_mask | input | 1 | MSI-X function mask from configuration space |
| cfg_req_id | input | 16 | Requester ID placed in the header |
| irq_valid | input | 1 | One-cycle interrupt request strobe |
| irq_vec | input | 3 | Vector index of the request |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_idx | input | 3 | Table entry index for the write |
| tbl_sel | input | 2 | Field select for the write |
| tbl_wdata | input | 32 | Table write data |
| pend_o | output | 8 | Pending bit per vector |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| tx_data | output | 32 | Transmit beat data |

## Verification
The hardest case to reach from the ports is a table rewrite that lands while a packet for the same vector is already launched but not yet drained. The bench forces tx_ready low and waits for tx_valid to rise. It then rewrites that vector's message value before releasing the sink, and it expects the old value in the payload and the new value only in a later packet. A second hard case is priority among vectors that are held back together. The bench sets the function mask, raises two vectors in reverse order, and then clears the mask, which brings the arbitration about on purpose.

// File: rtl/msix_pkg.sv
package msix_pkg;

    localparam int DW_BITS   = 32;
    localparam int FRAME_MAX = 5;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_DATA    = 2'd2,
        SEL_CTRL    = 2'd3
    } tbl_sel_e;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
        logic [31:0] ctrl;
    } msix_entry_t;

    typedef logic [FRAME_MAX-1:0][DW_BITS-1:0] frame_t;

    // fmt, type, R, TC, R, TD, EP, attr, AT, length
    function automatic logic [31:0] hdr_word0(input logic four_dw);
        return {(four_dw ? 3'b011 : 3'b010), 5'b00000, 1'b0, 3'b000,
                4'b0000, 1'b0, 1'b0, 2'b00, 2'b00, 10'd1};
    endfunction

    function automatic logic [31:0] hdr_word1(input logic [15:0] rid);
        return {rid, 8'h00, 4'b0000, 4'b1111};
    endfunction

endpackage

// File: rtl/msix_table.sv
module msix_table
    import msix_pkg::*;
#(
    parameter  int NUM_VEC = 8,
    localparam int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [VEC_W-1:0]   wr_idx,
    input  logic [1:0]         wr_sel,
    input  logic [31:0]        wr_data,
    input  logic [VEC_W-1:0]   rd_idx,
    output msix_entry_t        rd_entry,
    output logic [NUM_VEC-1:0] vec_mask
);

    msix_entry_t ent_flat [NUM_VEC];

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
        msix_entry_t ent_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '{addr: 64'd0, data: 32'd0, ctrl: 32'd1};
            end else if (wr_en && wr_idx == VEC_W'(g)) begin
                case (tbl_sel_e'(wr_sel))
                    SEL_ADDR_LO: ent_q.addr[31:0]  <= wr_data;
                    SEL_ADDR_HI: ent_q.addr[63:32] <= wr_data;
                    SEL_DATA:    ent_q.data        <= wr_data;
                    default:     ent_q.ctrl        <= wr_data;
                endcase
            end
        end
        assign ent_flat[g] = ent_q;
        assign vec_mask[g] = ent_q.ctrl[0];
    end

    assign rd_entry = ent_flat[rd_idx];

endmodule

// File: rtl/msix_pick.sv
module msix_pick #(
    parameter  int NUM_VEC = 8,
    localparam int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0] eligible,
    output logic               any,
    output logic [VEC_W-1:0]   sel
);

    always_comb begin
        sel = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (eligible[i]) sel = VEC_W'(i);
        end
    end

    assign any = |eligible;

endmodule

// File: rtl/msix_tx_ser.sv
module msix_tx_ser
    import msix_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  frame_t      frame,
    input  logic        four_dw,
    output logic        busy,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        tx_sop,
    output logic        tx_eop,
    output logic [31:0] tx_data
);

    localparam int IDX_W = $clog2(FRAME_MAX);

    frame_t           dw_q;
    logic             four_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = four_q ? IDX_W'(FRAME_MAX - 1) : IDX_W'(FRAME_MAX - 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            idx_q  <= '0;
            four_q <= 1'b0;
            dw_q   <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            idx_q  <= '0;
            four_q <= four_dw;
            dw_q   <= frame;
        end else if (busy && tx_ready) begin
            if (idx_q == last_idx) begin
                busy  <= 1'b0;
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign tx_valid = busy;
    assign tx_sop   = busy && (idx_q == '0);
    assign tx_eop   = busy && (idx_q == last_idx);
    assign tx_data  = dw_q[idx_q];

endmodule

// File: rtl/msix_tlp_gen.sv
module msix_tlp_gen
    import msix_pkg::*;
#(
    parameter  int NUM_VEC = 8,
    localparam int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_msix_en,
    input  logic               cfg_func_mask,
    input  logic [15:0]        cfg_req_id,
    input  logic               irq_valid,
    input  logic [VEC_W-1:0]   irq_vec,
    input  logic               tbl_wr_en,
    input  logic [VEC_W-1:0]   tbl_idx,
    input  logic [1:0]         tbl_sel,
    input  logic [31:0]        tbl_wdata,
    output logic [NUM_VEC-1:0] pend_o,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               tx_sop,
    output logic               tx_eop,
    output logic [31:0]        tx_data
);

    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] vec_mask;
    logic [NUM_VEC-1:0] eligible;
    logic [NUM_VEC-1:0] set_vec;
    logic [NUM_VEC-1:0] clr_vec;
    logic [VEC_W-1:0]   pick_idx;
    logic               pick_any;
    logic               busy;
    logic               launch;
    logic               four_dw;
    msix_entry_t        cur_ent;
    frame_t             frame;

    msix_table #(.NUM_VEC(NUM_VEC)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_wr_en),
        .wr_idx   (tbl_idx),
        .wr_sel   (tbl_sel),
        .wr_data  (tbl_wdata),
        .rd_idx   (pick_idx),
        .rd_entry (cur_ent),
        .vec_mask (vec_mask)
    );

    assign eligible = pend_q & ~vec_mask;

    msix_pick #(.NUM_VEC(NUM_VEC)) u_pick (
        .eligible (eligible),
        .any      (pick_any),
        .sel      (pick_idx)
    );

    assign launch = pick_any && cfg_msix_en && !cfg_func_mask && !busy;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (irq_valid) set_vec[irq_vec] = 1'b1;
        if (launch)    clr_vec[pick_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    assign pend_o = pend_q;

    always_comb begin
        four_dw  = |cur_ent.addr[63:32];
        frame    = '0;
        frame[0] = hdr_word0(four_dw);
        frame[1] = hdr_word1(cfg_req_id);
        if (four_dw) begin
            frame[2] = cur_ent.addr[63:32];
            frame[3] = {cur_ent.addr[31:2], 2'b00};
            frame[4] = cur_ent.data;
        end else begin
            frame[2] = {cur_ent.addr[31:2], 2'b00};
            frame[3] = cur_ent.data;
        end
    end

    msix_tx_ser u_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .frame    (frame),
        .four_dw  (four_dw),
        .busy     (busy),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_sop   (tx_sop),
        .tx_eop   (tx_eop),
        .tx_data  (tx_data)
    );

endmodule

// File: rtl/msix_tlp_gen_chk.sv
module msix_tlp_gen_chk #(
    parameter  int NUM_VEC = 8,
    localparam int VEC_W   = $clog2(NUM_VEC)
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_msix_en,
    input logic               cfg_func_mask,
    input logic [NUM_VEC-1:0] pend_o,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic               tx_sop,
    input logic               tx_eop,
    input logic [31:0]        tx_data
);

    logic [2:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst)                       beat_q <= '0;
        else if (tx_valid && tx_ready) beat_q <= tx_eop ? 3'd0 : beat_q + 3'd1;
    end

    AST_SOP_HEADER: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_sop |-> (tx_data == 32'h4000_0001 || tx_data == 32'h6000_0001)); // R1

    AST_BYTE_ENABLES: assert property (@(posedge clk) disable iff (rst)
        tx_valid && beat_q == 3'd1 |-> tx_data[15:0] == 16'h000F); // R2

    AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !$past(tx_valid) |-> $past(cfg_msix_en)); // R4

    AST_START_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !$past(tx_valid) |-> !$past(cfg_func_mask)); // R5

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)); // R9

    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready && !tx_eop |=> tx_valid && !tx_sop); // R9

    AST_FIRST_IS_SOP: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !$past(tx_valid) |-> tx_sop); // R9

endmodule

bind msix_tlp_gen msix_tlp_gen_chk #(.NUM_VEC(NUM_VEC)) u_chk (.*);

// File: tb/msix_tlp_gen_bench.sv
`timescale 1ns/1ps
module msix_tlp_gen_bench;

    localparam int NV = 8;
    localparam logic [15:0] RID = 16'hBEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_msix_en = 1'b0;
    logic        cfg_func_mask = 1'b0;
    logic        irq_valid = 1'b0;
    logic [2:0]  irq_vec = '0;
    logic        tbl_wr_en = 1'b0;
    logic [2:0]  tbl_idx = '0;
    logic [1:0]  tbl_sel = '0;
    logic [31:0] tbl_wdata = '0;
    logic [NV-1:0] pend_o;
    logic        tx_valid, tx_sop, tx_eop;
    logic        tx_ready = 1'b1;
    logic [31:0] tx_data;

    always #2 clk = ~clk;

    msix_tlp_gen u_msix_tlp_gen (
        .clk(clk), .rst(rst), .cfg_msix_en(cfg_msix_en), .cfg_func_mask(cfg_func_mask),
        .cfg_req_id(RID), .irq_valid(irq_valid), .irq_vec(irq_vec),
        .tbl_wr_en(tbl_wr_en), .tbl_idx(tbl_idx), .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata),
        .pend_o(pend_o), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data)
    );

    typedef struct {
        logic [31:0] d;
        logic        sop;
        logic        eop;
        string       req;
    } beat_t;

    beat_t exp_q [$];
    int checks = 0;
    int fails  = 0;

    logic [31:0] sh_lo [NV];
    logic [31:0] sh_hi [NV];
    logic [31:0] sh_dat [NV];

    logic       stall = 1'b0;
    logic       hold_low = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    always @(posedge clk) begin
        lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready <= hold_low ? 1'b0 : (stall ? lfsr[0] : 1'b1);
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R5/R6 unexpected beat", tx_data, 32'h0);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                check(tx_data == e.d, e.req, tx_data, e.d);
                check({tx_sop, tx_eop} == {e.sop, e.eop}, "R9 markers",
                      {30'd0, tx_sop, tx_eop}, {30'd0, e.sop, e.eop});
            end
        end
    end

    task automatic push(input logic [31:0] d, input logic s, input logic e, input string r);
        beat_t b;
        b.d = d; b.sop = s; b.eop = e; b.req = r;
        exp_q.push_back(b);
    endtask

    task automatic push_pkt(input int v);
        bit four;
        four = (sh_hi[v] != 32'd0);
        push(four ? 32'h6000_0001 : 32'h4000_0001, 1'b1, 1'b0, "R1 header dword0");
        push({RID, 8'h00, 8'h0F}, 1'b0, 1'b0, "R2 header dword1");
        if (four) begin
            push(sh_hi[v], 1'b0, 1'b0, "R3 address high");
            push({sh_lo[v][31:2], 2'b00}, 1'b0, 1'b0, "R3 address low");
        end else begin
            push({sh_lo[v][31:2], 2'b00}, 1'b0, 1'b0, "R3 address low");
        end
        push(sh_dat[v], 1'b0, 1'b1, "R3 payload");
    endtask

    task automatic twrite(input int idx, input int sel, input logic [31:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_idx = 3'(idx); tbl_sel = 2'(sel); tbl_wdata = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic fire(input int v);
        @(negedge clk);
        irq_valid = 1'b1; irq_vec = 3'(v);
        @(negedge clk);
        irq_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((exp_q.size() != 0 || tx_valid) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 packet drained", exp_q.size(), 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            sh_lo[v]  = 32'h1000_0000 + 32'(v) * 32'h40 + 32'h3;
            sh_hi[v]  = (v % 2 == 1) ? 32'h0000_00A0 + 32'(v) : 32'd0;
            sh_dat[v] = 32'hD000_0000 | 32'(v);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_valid == 1'b0, "R10 tx_valid after reset", 32'(tx_valid), 0);
        check(pend_o == 8'h00, "R10 pend after reset", 32'(pend_o), 0);

        // vectors start masked after reset: request stays pending
        cfg_msix_en = 1'b1;
        fire(0);
        repeat (5) @(negedge clk);
        check(pend_o == 8'h01, "R10 R6 reset mask holds vector 0", 32'(pend_o), 32'h01);

        for (int v = 0; v < NV; v++) begin
            twrite(v, 0, sh_lo[v]);
            twrite(v, 1, sh_hi[v]);
            twrite(v, 2, sh_dat[v]);
        end
        push_pkt(0);
        twrite(0, 3, 32'h0);
        wait_idle();
        check(pend_o == 8'h00, "R7 pend clears after send", 32'(pend_o), 0);

        for (int v = 1; v < NV; v++) twrite(v, 3, 32'h0);
        for (int v = 1; v < NV; v++) begin
            stall = (v >= 4);
            push_pkt(v);
            fire(v);
            wait_idle();
        end
        stall = 1'b1;

        // global enable off
        cfg_msix_en = 1'b0;
        fire(3);
        repeat (8) @(negedge clk);
        check(pend_o == 8'h08, "R4 pending while disabled", 32'(pend_o), 32'h08);
        check(tx_valid == 1'b0, "R4 nothing sent while disabled", 32'(tx_valid), 0);
        push_pkt(3);
        cfg_msix_en = 1'b1;
        wait_idle();
        check(pend_o == 8'h00, "R7 R4 pend clears", 32'(pend_o), 0);

        // function mask and priority
        cfg_func_mask = 1'b1;
        fire(5);
        fire(2);
        repeat (8) @(negedge clk);
        check(pend_o == 8'h24, "R5 pending under function mask", 32'(pend_o), 32'h24);
        check(tx_valid == 1'b0, "R5 nothing sent under function mask", 32'(tx_valid), 0);
        push_pkt(2);
        push_pkt(5);
        cfg_func_mask = 1'b0;
        wait_idle();
        check(pend_o == 8'h00, "R8 both sent lowest first", 32'(pend_o), 0);

        // per-vector mask
        twrite(6, 3, 32'h1);
        fire(6);
        repeat (8) @(negedge clk);
        check(pend_o == 8'h40, "R6 pending under vector mask", 32'(pend_o), 32'h40);
        push_pkt(6);
        twrite(6, 3, 32'h0);
        wait_idle();
        check(pend_o == 8'h00, "R6 R7 sent after unmask", 32'(pend_o), 0);

        // snapshot at launch
        hold_low = 1'b1;
        push_pkt(1);
        fire(1);
        while (!tx_valid) @(negedge clk);
        twrite(1, 2, 32'hCAFE_0011);
        repeat (4) @(negedge clk);
        hold_low = 1'b0;
        wait_idle();
        sh_dat[1] = 32'hCAFE_0011;
        push_pkt(1);
        fire(1);
        wait_idle();
        check(pend_o == 8'h00, "R11 pend clear at end", 32'(pend_o), 0);

        summary();
        $finish;
    end

endmodule